// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a physical frame after the translation cache has missed. It takes a 20-bit virtual page number and reads two 32-bit entries from memory. The first is a directory entry, selected by the upper ten bits of the page number. The second is a leaf entry in the table page that the directory entry points to, selected by the lower ten bits. The page offset is not used here, because pages are 4 KB and the offset passes through unchanged.

A walk ends in one of two ways. If both entries are present, the block pulses a completion strobe and returns the frame number together with six flag bits. If either entry is absent, it pulses a fault strobe and reports which level was missing. The block handles one walk at a time, and it has a single memory read port with one read outstanding.

The table base lives in an internal register. The operating system rewrites it on a context switch, and each walk uses the base value held when that walk was accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done`, `fault` and `mem_req_valid` are all low, and the table base register holds zero.
- R2: A lookup is accepted in a cycle where `req_valid` is high and `busy` is low. `busy` rises in the next cycle and stays high until the cycle in which `done` or `fault` is high, where it is low. A `req_valid` raised while `busy` is high starts no walk.
- R3: The first memory read of a walk uses address {base[31:12], vpn[19:10], 2'b00}. This is the base plus four times the directory index, and the low 12 bits of the base are ignored.
- R4: When the directory entry has bit 0 (present) set, the second read uses address {dir_entry[31:12], vpn[9:0], 2'b00}.
- R5: When the directory entry has bit 0 clear, `fault` pulses in the cycle after the response with `fault_level` = 0, and no second read is issued.
- R6: When the leaf entry has bit 0 clear, `fault` pulses in the cycle after the response with `fault_level` = 1, and `done` stays low.
- R7: When the leaf entry is present, `done` pulses in the cycle after the response. `frame` equals leaf[31:12] and `flags` equals leaf[6:1]. Within `flags`, [0] is read, [1] is write, [2] is execute, [3] is referenced, [4] is modified and [5] is caching-disabled.
- R8: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen. No request is raised while a response is still owed or while the walker is idle. A response may arrive any number of cycles later.
- R9: A write through `base_we` affects only walks accepted in later cycles. A walk already in progress keeps the base value it was started with.
- R10: `done` and `fault` are never high together, and each is high for a single cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base; bits 11:0 ignored |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 20 | Virtual page number to translate |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |
| done | output | 1 | Translation complete |
| frame | output | 20 | Physical frame number |
| flags | output | 6 | read, write, exec, referenced, modified, caching-disabled |
| fault | output | 1 | Walk ended on an absent entry |
| fault_level | output | 1 | 0 = directory absent, 1 = leaf absent |

## Verification
If the walk state is wrong, the port-level sequence breaks. A bad address appears at the very next memory handshake. A wrong present decision shows up one cycle after the response: a strobe of the wrong kind, a second read that should not happen, or one that is missing. If a stale or freshly written base is latched at the wrong moment, the first read of the affected walk goes to a different directory address. An acceptance made while busy shows up as an unexpected read address or result, several cycles before the walk in progress would finish.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int PTE_W = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   base_we,
  input  logic [PTE_W-1:0]       base_wdata,
  input  logic                   req_valid,
  input  logic [VA_W-OFF_W-1:0]  req_vpn,
  output logic                   busy,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [PTE_W-1:0]       mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  output logic                   done,
  output logic [PTE_W-OFF_W-1:0] frame,
  output logic [5:0]             flags,
  output logic                   fault,
  output logic                   fault_level
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PTE_W - OFF_W;
  localparam int ESH   = OFF_W - IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_LEAF_REQ, S_LEAF_WAIT} st_t;

  st_t              st;
  logic [PFN_W-1:0] base_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PTE_W-1:0] addr_q;

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_DIR_REQ) || (st == S_LEAF_REQ);
  assign mem_req_addr  = addr_q;

  wire present = mem_rsp_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_q      <= '0;
      vpn_q       <= '0;
      addr_q      <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_level <= 1'b0;
      frame       <= '0;
      flags       <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (base_we) base_q <= base_wdata[PTE_W-1:OFF_W];
      case (st)
        S_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          addr_q <= {base_q, req_vpn[VPN_W-1 -: IDX_W], {ESH{1'b0}}};
          st     <= S_DIR_REQ;
        end
        S_DIR_REQ:  if (mem_req_ready) st <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid) begin
          if (present) begin
            addr_q <= {mem_rsp_data[PTE_W-1:OFF_W], vpn_q[IDX_W-1:0], {ESH{1'b0}}};
            st     <= S_LEAF_REQ;
          end else begin
            fault       <= 1'b1;
            fault_level <= 1'b0;
            st          <= S_IDLE;
          end
        end
        S_LEAF_REQ: if (mem_req_ready) st <= S_LEAF_WAIT;
        S_LEAF_WAIT: if (mem_rsp_valid) begin
          if (present) begin
            done  <= 1'b1;
            frame <= mem_rsp_data[PTE_W-1:OFF_W];
            flags <= mem_rsp_data[6:1];
          end else begin
            fault       <= 1'b1;
            fault_level <= 1'b1;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !busy |=> busy); // R2
  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !busy); // R2
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault); // R10
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 0, rst_n = 0;
  logic        base_we = 0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 0;
  logic [19:0] req_vpn = '0;
  logic        busy, mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0;
  logic        done, fault, fault_level;
  logic [19:0] frame;
  logic [5:0]  flags;

  always #2 clk = ~clk;

  pt_walker u0 (.clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vpn(req_vpn), .busy(busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .frame(frame), .flags(flags), .fault(fault),
    .fault_level(fault_level));

  typedef struct packed { logic is_fault; logic lvl; logic [19:0] pfn; logic [5:0] fl; } res_t;

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] exp_addr [$];
  string       exp_tag [$];
  res_t        exp_res [$];
  logic [31:0] cur_base = '0;
  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  task automatic start_walk(input logic [19:0] vpn);
    logic [31:0] da, de, la, le;
    res_t r;
    da = {cur_base[31:12], vpn[19:10], 2'b00};
    exp_addr.push_back(da); exp_tag.push_back("R3");
    de = rd(da);
    if (!de[0]) r = '{1'b1, 1'b0, 20'h0, 6'h0};
    else begin
      la = {de[31:12], vpn[9:0], 2'b00};
      exp_addr.push_back(la); exp_tag.push_back("R4");
      le = rd(la);
      if (!le[0]) r = '{1'b1, 1'b1, 20'h0, 6'h0};
      else        r = '{1'b0, 1'b0, le[31:12], le[6:1]};
    end
    exp_res.push_back(r);
    @(negedge clk);
    req_valid = 1; req_vpn = vpn;
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R2", "busy after accept", busy, 1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    base_we = 1; base_wdata = v;
    @(negedge clk);
    base_we = 0;
    cur_base = v;
  endtask

  // memory responder
  initial begin
    int k = 0, lat = 0;
    bit pend = 0;
    logic [31:0] data = '0;
    logic [31:0] ea;
    string tg;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      if (pend) begin
        if (lat == 0) begin mem_rsp_valid = 1; mem_rsp_data = data; pend = 0; end
        else lat--;
      end
      k++;
      mem_req_ready = !pend && ((k % 4) != 2);
      if (mem_req_valid && mem_req_ready && rst_n) begin
        if (exp_addr.size() == 0) chk(0, "R2", "unexpected read", mem_req_addr, 0);
        else begin
          ea = exp_addr.pop_front(); tg = exp_tag.pop_front();
          chk(mem_req_addr === ea, tg, "read address", mem_req_addr, ea);
        end
        data = rd(mem_req_addr);
        pend = 1; lat = (k * 7) % 5;
      end
    end
  end

  // result monitor
  initial begin
    res_t e;
    forever begin
      @(negedge clk);
      if (rst_n && (done || fault)) begin
        chk(!(done && fault), "R10", "done and fault together", {done, fault}, 2'b00);
        if (exp_res.size() == 0) chk(0, "R2", "unexpected result", {done, fault}, 0);
        else begin
          e = exp_res.pop_front();
          if (e.is_fault) begin
            chk(fault === 1'b1, e.lvl ? "R6" : "R5", "fault strobe", fault, 1);
            chk(fault_level === e.lvl, e.lvl ? "R6" : "R5", "fault level", fault_level, e.lvl);
          end else begin
            chk(done === 1'b1, "R7", "done strobe", done, 1);
            chk(frame === e.pfn, "R7", "frame", frame, e.pfn);
            chk(flags === e.fl, "R7", "flags", flags, e.fl);
          end
        end
      end
    end
  end

  initial begin
    #400000;
    chk(0, "R2", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    mem_img[32'h0001_0014] = 32'h0002_0001;
    mem_img[32'h0002_048C] = 32'hABCD_E07F;
    mem_img[32'h0002_0FFC] = 32'h1234_500B;
    mem_img[32'h0002_0000] = 32'h0FFF_F07E;
    mem_img[32'h0001_0FFC] = 32'h0003_0000;
    mem_img[32'h0001_0000] = 32'h0004_0001;
    mem_img[32'h0004_0004] = 32'h0077_7021;
    mem_img[32'h0005_0014] = 32'h0006_0001;
    mem_img[32'h0006_048C] = 32'h9999_9043;
    mem_img[32'h0000_0014] = 32'h0008_0001;
    mem_img[32'h0008_048C] = 32'h5555_5003;

    repeat (3) @(negedge clk);
    chk(busy === 0 && done === 0 && fault === 0 && mem_req_valid === 0, "R1",
        "outputs in reset", {busy, done, fault, mem_req_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: base resets to zero, so directory comes from address 0x14
    start_walk({10'h005, 10'h123}); wait_idle();
    set_base(32'h0001_0000);
    start_walk({10'h005, 10'h123}); wait_idle();   // R7 all flags
    start_walk({10'h005, 10'h3FF}); wait_idle();   // R4 top index
    start_walk({10'h005, 10'h000}); wait_idle();   // R6 leaf absent
    start_walk({10'h3FF, 10'h2AA}); wait_idle();   // R5 directory absent
    start_walk({10'h000, 10'h001}); wait_idle();   // R3 index zero
    // R2: requests while busy are dropped
    start_walk({10'h005, 10'h123});
    req_valid = 1; req_vpn = {10'h000, 10'h001};
    @(negedge clk);
    chk(busy === 1'b1, "R2", "still busy during stray request", busy, 1);
    req_valid = 0;
    wait_idle();
    // R9: base write during a walk affects only later walks
    start_walk({10'h000, 10'h001});
    set_base(32'h0005_0ABC);
    wait_idle();
    start_walk({10'h005, 10'h123}); wait_idle();
    repeat (8) @(negedge clk);
    chk(exp_addr.size() == 0, "R8", "reads left unissued", exp_addr.size(), 0);
    chk(exp_res.size() == 0, "R10", "results left unreported", exp_res.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule